// File: doc/BRIEF.md
# Single-Stage Recursive Decimation Filter

This block low-pass filters a signed sample stream and reduces its rate by an integer factor M in the same stage. The response is a parallel sum of NSEC first-order recursive sections, each with its own pole `a`. Each section is rewritten so that its feedback term is a^M applied once per output sample. Inside a frame, the samples are only weighted and summed, never fed back. The rate reduction therefore sits ahead of the recursion. The loop runs at the output rate, and there is no full-rate filter followed by a discarding downsampler.

A phase counter steps once per accepted sample. It acts as a commutator: the sample at frame position p is weighted by a^(M-1-p), so the newest sample carries weight 1 and the oldest carries a^(M-1). Each section adds the weighted products of one frame into a partial sum. On the last sample of the frame, the section forms its new state as round(a^M * state) + partial sum. The states of all sections are added and rounded to the input format, and the result is clamped and registered as one output.

Both sides of the block use valid/ready handshakes. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on a clock edge where `out_valid` and `out_ready` are both high. The block holds one result. While that result is not taken, `in_ready` is low. The source must then keep its sample and wait, and `out_data` stays frozen.

Top module: `iir_decimator`

## Requirements
- R1: After synchronous reset (`rst` high), `out_valid` is 0 and `in_ready` is 1. The phase counter and every section state are zero, so the first result covers exactly the first M accepted samples.
- R2: A sample is consumed only on an edge where `in_valid` and `in_ready` are both high. Cycles without that, whatever `in_data` holds, leave the phase and the sums unchanged, so the results are the same as for the same samples sent back to back.
- R3: Exactly one result is produced per M accepted samples. `out_valid` is high in the cycle after the M-th sample of a frame is accepted. When the result is taken at once, `out_valid` is low again in the following cycle.
- R4: Each result equals, within one LSB, the sum over sections of the full-rate recursion y[n] = a*y[n-1] + x[n], sampled at the last sample of each frame and rounded to nearest. The poles are signed Q1.15 parameters (default +0.5 and -0.5), and M = 10 by default.
- R5: Within a frame, the sample at position p (0 = first accepted) is weighted by a^(M-1-p). An impulse placed mid-frame gives a result of the impulse scaled by the sum of those weights.
- R6: Section feedback uses a^M and is applied only on the last sample of a frame. After an impulse, later all-zero frames decay by a^M per frame for each section.
- R7: The result is clamped to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1] and does not wrap.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` is stable, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | DW | Signed filtered, decimated result |

## Verification
The M-th sample of a frame is accepted on a rising edge. Its result is due in the very next cycle, with nothing pipelined in between, so the bench samples `out_valid` at the falling edge that follows that acceptance. If the sink is ready, the bench also checks that `out_valid` has dropped one cycle later. Result values are compared against a full-rate floating-point recursion whenever a handshake is seen at a falling edge, so any stall only delays the comparison. During a forced stall, the bench checks at each falling edge that the held value, `out_valid` and the low `in_ready` stay unchanged for several cycles.

// File: rtl/iir_dec_pkg.sv
package iir_dec_pkg;
  // fraction bits of the Q1.15 coefficient format
  localparam int CF = 15;

  // a^n in Q(.)15, each multiply rounded to nearest; a^0 is exactly one
  function automatic longint pow_fix(input longint a, input int n);
    longint r;
    r = longint'(1) <<< CF;
    for (int i = 0; i < n; i++)
      r = (r * a + (longint'(1) <<< (CF - 1))) >>> CF;
    return r;
  endfunction
endpackage

// File: rtl/iir_dec_commutator.sv
module iir_dec_commutator #(
  parameter int M = 10,
  localparam int PW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [PW-1:0] phase,
  output logic          last
);
  assign last = (phase == PW'(M - 1));

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= last ? '0 : phase + PW'(1);
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= PW'(M - 1));
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase));
  // R3
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    step && last |=> phase == '0);
endmodule

// File: rtl/iir_dec_section.sv
module iir_dec_section
  import iir_dec_pkg::*;
#(
  parameter int DW = 16,
  parameter int M  = 10,
  parameter int SW = 37,
  parameter logic signed [CF:0] POLE = 16'sh4000,
  localparam int PW = (M > 1) ? $clog2(M) : 1,
  localparam int CW = CF + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 last,
  input  logic [PW-1:0]        phase,
  input  logic signed [DW-1:0] in_data,
  output logic signed [SW-1:0] state_nxt
);
  localparam logic signed [CW-1:0] AM = CW'(pow_fix(longint'(POLE), M));

  function automatic logic signed [SW-1:0] clip(input logic signed [SW:0] v);
    if (v[SW] != v[SW-1])
      clip = v[SW] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    else
      clip = v[SW-1:0];
  endfunction

  // phase weights a^k, k counted back from the newest sample of the frame
  logic signed [CW-1:0] coef [M];
  for (genvar k = 0; k < M; k++) begin : g_coef
    localparam logic signed [CW-1:0] CK = CW'(pow_fix(longint'(POLE), k));
    assign coef[k] = CK;
  end

  logic [PW-1:0]           widx;
  logic signed [DW+CW-1:0] prod;
  logic signed [SW-1:0]    acc, state, base, w_sum, fb;
  logic signed [SW+CW-1:0] fbp;
  logic signed [SW:0]      fbr;

  assign widx  = PW'(M - 1) - phase;
  assign prod  = in_data * coef[widx];
  assign base  = (phase == '0) ? '0 : acc;
  assign w_sum = clip((SW+1)'(base) + (SW+1)'(prod));
  assign fbp   = state * AM;
  assign fbr   = (SW+1)'((fbp + (SW+CW)'(1 << (CF - 1))) >>> CF);
  assign fb    = clip(fbr);
  assign state_nxt = clip((SW+1)'(fb) + (SW+1)'(w_sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      state <= '0;
    end else if (step) begin
      acc <= w_sum;
      if (last) state <= state_nxt;
    end
  end

  // R6
  state_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !(step && last) |=> $stable(state));
  // R2
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc));
endmodule

// File: rtl/iir_decimator.sv
module iir_decimator
  import iir_dec_pkg::*;
#(
  parameter int DW   = 16,
  parameter int M    = 10,
  parameter int NSEC = 2,
  parameter int GB   = 6,
  parameter logic [NSEC*(CF+1)-1:0] POLES = {16'hC000, 16'h4000},
  localparam int SW = DW + CF + GB,
  localparam int PW = (M > 1) ? $clog2(M) : 1,
  localparam int TW = SW + $clog2(NSEC) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          step, last;
  logic [PW-1:0] phase;

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  iir_dec_commutator #(.M(M)) u_comm (
    .clk(clk), .rst(rst), .step(step), .phase(phase), .last(last)
  );

  logic signed [SW-1:0] sec_nxt [NSEC];
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    iir_dec_section #(
      .DW(DW), .M(M), .SW(SW), .POLE(POLES[s*(CF+1) +: (CF+1)])
    ) u_sec (
      .clk(clk), .rst(rst), .step(step), .last(last), .phase(phase),
      .in_data($signed(in_data)), .state_nxt(sec_nxt[s])
    );
  end

  logic signed [TW-1:0] tot, rnd;
  logic        [DW-1:0] y;

  always_comb begin
    tot = '0;
    for (int s = 0; s < NSEC; s++) tot = tot + TW'(sec_nxt[s]);
  end

  assign rnd = (tot + TW'(1 << (CF - 1))) >>> CF;

  always_comb begin
    if (rnd > TW'((1 << (DW - 1)) - 1))
      y = {1'b0, {(DW-1){1'b1}}};
    else if (rnd < -TW'(1 << (DW - 1)))
      y = {1'b1, {(DW-1){1'b0}}};
    else
      y = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (step && last) begin
      out_valid <= 1'b1;
      out_data  <= y;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R3
  frame_out_chk: assert property (@(posedge clk) disable iff (rst)
    step && last |=> out_valid);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/iir_decimator_test.sv
`timescale 1ns/1ps
module iir_decimator_test;
  localparam int DW = 16;
  localparam int M  = 10;
  localparam real A0 = 0.5;
  localparam real A1 = -0.5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  iir_decimator #(.DW(DW), .M(M)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  real y0 = 0.0, y1 = 0.0;
  int cnt = 0, frames = 0, outs = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // full-rate reference recursion, one result kept per M samples
  task automatic model_step(input int x);
    real s, r;
    y0 = A0 * y0 + x;
    y1 = A1 * y1 + x;
    cnt++;
    if (cnt == M) begin
      cnt = 0;
      frames++;
      s = y0 + y1;
      r = $floor(s + 0.5);
      if (r > 32767.0) r = 32767.0;
      if (r < -32768.0) r = -32768.0;
      exp_q.push_back(int'(r));
    end
  endtask

  task automatic send(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    model_step(x);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 16'hA5C3;
    #1;
    if (cnt == 0) begin
      // R3: result due the cycle after the M-th accepted sample
      chk(out_valid == 1'b1, "R3", int'(out_valid), 1);
      if (out_ready) begin
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R3", int'(out_valid), 0);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = DW'(i * 9127 + 333);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst && out_valid && out_ready) begin
        int got, e;
        got = int'($signed(out_data));
        outs++;
        if (exp_q.size() == 0) begin
          chk(1'b0, tag, got, 0);
        end else begin
          e = exp_q.pop_front();
          chk((got - e) <= 1 && (e - got) <= 1, tag, got, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

    tag = "R1";
    for (int i = 0; i < M; i++) send(1000 + 100 * i);

    tag = "R4";
    for (int i = 0; i < 3 * M; i++) send(((i * 3779) % 20000) - 10000);

    // R2: gaps with changing in_data while in_valid is low
    tag = "R2";
    for (int i = 0; i < 2 * M; i++) begin
      send(((i * 7919) % 16000) - 8000);
      idle(i % 3);
    end

    // R5: impulse mid-frame
    tag = "R5";
    for (int i = 0; i < M; i++) send(i == 3 ? 12000 : 0);

    // R6: impulse on last position, then decay over zero frames
    tag = "R6";
    for (int i = 0; i < 4 * M; i++) send(i == M - 1 ? 20000 : 0);

    // R7: saturation both ways
    tag = "R7";
    for (int i = 0; i < 3 * M; i++) send(32767);
    for (int i = 0; i < 3 * M; i++) send(-32768);

    // R8: back-pressure
    tag = "R8";
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < M; i++) send(500 * i - 2000);
    d0 = int'(out_data);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
      chk(int'(out_data) == d0, "R8", int'(out_data), d0);
      chk(in_ready == 1'b0, "R8", int'(in_ready), 0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < M; i++) send(-300 * i);

    idle(20);
    // R3: one result per frame, none left pending
    chk(outs == frames, "R3", outs, frames);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule